// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

The controller gathers up to 32 interrupt sources into a status word, masks that word with a per-source enable word and raises one request line toward a processor. Each source is fixed at build time as edge-triggered or level-sensitive through a bitmask parameter (`EDGE_MASK`, bit n set means source n is edge-triggered). An edge source latches on a rising input and stays latched until software acknowledges it. A level source is re-latched on every cycle its input is high.

Software uses a word-addressed register port with an address, a write strobe, write data and registered read data. Enable bits can be changed atomically through separate set and clear registers, or replaced as a whole word. Status bits are cleared by writing ones to an acknowledge register. A vector register reports the lowest-numbered enabled pending source, or all ones when there is none. A two-bit master register gates the request line.

The request path is a three-state machine. `REQ_OFF` is held while master bit 0 is clear. `REQ_QUIET` means the controller is on and nothing is pending. `REQ_RAISED` means the controller is on and at least one source is pending, and it drives the request. The transitions are: any state goes to `REQ_OFF` when master bit 0 is 0. `REQ_OFF` goes to `REQ_QUIET` or `REQ_RAISED` once master bit 0 is 1, depending on whether anything is pending. `REQ_QUIET` goes to `REQ_RAISED` when a source becomes pending. `REQ_RAISED` goes back to `REQ_QUIET` when nothing is pending.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, status, enable and master read zero, the request output is low, and the vector reads 0xFFFFFFFF.
- R2: An edge source sets its status bit on a rising input edge. The bit stays set after the input falls, until it is acknowledged. A source held high is not re-latched after an acknowledge.
- R3: A level source sets its status bit on every cycle its input is high, so an acknowledge written while the input is high leaves the bit set. Once the input is low, the acknowledge clears the bit.
- R4: A write to set-enable (offset 4) sets only the enable bits written as one. A write to clear-enable (offset 5) clears only the enable bits written as one. All other enable bits keep their value.
- R5: A write to the enable register (offset 2) replaces the whole enable word. Writing zero disables every source in one access.
- R6: A write to acknowledge (offset 3) clears every status bit written as one. Writing 0xFFFFFFFF clears them all.
- R7: The pending register (offset 1) reads as status AND enable. Status (offset 0) shows a latched source even while that source is disabled.
- R8: The vector register (offset 6) returns the index of the lowest-numbered pending source, or 0xFFFFFFFF when no source is pending.
- R9: The request output is high exactly one cycle after some pending bit is set while master bit 0 is 1. Master bit 1 alone does not assert it.
- R10: Register offsets are 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Read data appears on the cycle after the address is presented. Offsets 3, 4 and 5 read zero. Writes to offsets 0, 1 and 6 have no effect.
- R11: The master register (offset 7) stores write-data bits 1:0 and reads zero in all bits above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source inputs, bit n is source n |
| reg_addr | input | 3 | Word offset of the register accessed |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the address of the previous cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The capture logic is driven with single-cycle pulses and with inputs held high, on both edge and level sources. This separates latch-until-acknowledge behaviour from re-latch-while-high behaviour, especially when an acknowledge arrives while the input is still high. The enable word is changed through set, clear and whole-word writes, with patterns that overlap bits already set, so a non-atomic update would show. Several sources are made pending at once to check that the vector reports the lowest index. Master values 0, 1, 2 and 3 are tried to confirm that only bit 0 gates the request.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        OFS_STATUS  = 3'd0,
        OFS_PENDING = 3'd1,
        OFS_ENABLE  = 3'd2,
        OFS_ACK     = 3'd3,
        OFS_SET_EN  = 3'd4,
        OFS_CLR_EN  = 3'd5,
        OFS_VECTOR  = 3'd6,
        OFS_MASTER  = 3'd7
    } reg_ofs_e;

    typedef enum logic [1:0] {
        REQ_OFF    = 2'd0,
        REQ_QUIET  = 2'd1,
        REQ_RAISED = 2'd2
    } req_state_e;

    typedef struct packed {
        logic wr_enable;
        logic wr_set;
        logic wr_clr;
        logic wr_ack;
        logic wr_master;
    } wr_dec_t;

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int                 NUM_SRC   = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_bits,
    output logic [NUM_SRC-1:0] status_q
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (EDGE_MASK[g]) begin : g_edge
            logic prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q      <= 1'b0;
                    status_q[g] <= 1'b0;
                end else begin
                    prev_q      <= src_i[g];
                    status_q[g] <= (status_q[g] & ~ack_bits[g]) | (src_i[g] & ~prev_q);
                end
            end
        end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    status_q[g] <= 1'b0;
                end else begin
                    status_q[g] <= (status_q[g] & ~ack_bits[g]) | src_i[g];
                end
            end
        end
    end

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_dec_t            wr_dec,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [1:0]         master_wdata,
    output logic [NUM_SRC-1:0] enable_q,
    output logic [1:0]         master_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_dec.wr_enable) begin
            enable_q <= wdata;
        end else if (wr_dec.wr_set) begin
            enable_q <= enable_q | wdata;
        end else if (wr_dec.wr_clr) begin
            enable_q <= enable_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 2'b00;
        end else if (wr_dec.wr_master) begin
            master_q <= master_wdata;
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_on,
    input  logic pend_any,
    output logic irq_o
);

    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_OFF: begin
                if (master_on) begin
                    state_d = pend_any ? REQ_RAISED : REQ_QUIET;
                end
            end
            REQ_QUIET: begin
                if (!master_on) begin
                    state_d = REQ_OFF;
                end else if (pend_any) begin
                    state_d = REQ_RAISED;
                end
            end
            REQ_RAISED: begin
                if (!master_on) begin
                    state_d = REQ_OFF;
                end else if (!pend_any) begin
                    state_d = REQ_QUIET;
                end
            end
            default: state_d = REQ_OFF;
        endcase
    end

    always_comb begin
        irq_o = (state_q == REQ_RAISED);
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DATA_W    = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'h0000_FF0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    wr_dec_t              wr_dec;
    logic [NUM_SRC-1:0]   ack_bits;
    logic [NUM_SRC-1:0]   status_q;
    logic [NUM_SRC-1:0]   enable_q;
    logic [1:0]           master_q;
    logic [NUM_SRC-1:0]   pending;
    logic                 vec_valid;
    logic [IDX_W-1:0]     vec_idx;
    logic [DATA_W-1:0]    rd_next;

    always_comb begin
        wr_dec = '0;
        if (reg_wr) begin
            unique case (reg_ofs_e'(reg_addr))
                OFS_ENABLE: wr_dec.wr_enable = 1'b1;
                OFS_SET_EN: wr_dec.wr_set    = 1'b1;
                OFS_CLR_EN: wr_dec.wr_clr    = 1'b1;
                OFS_ACK:    wr_dec.wr_ack    = 1'b1;
                OFS_MASTER: wr_dec.wr_master = 1'b1;
                default:    wr_dec = '0;
            endcase
        end
    end

    always_comb begin
        ack_bits = wr_dec.wr_ack ? reg_wdata[NUM_SRC-1:0] : '0;
    end

    irq_capture #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .ack_bits (ack_bits),
        .status_q (status_q)
    );

    irq_mask_regs #(
        .NUM_SRC (NUM_SRC)
    ) u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_dec       (wr_dec),
        .wdata        (reg_wdata[NUM_SRC-1:0]),
        .master_wdata (reg_wdata[1:0]),
        .enable_q     (enable_q),
        .master_q     (master_q)
    );

    always_comb begin
        pending = status_q & enable_q;
    end

    irq_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_prio (
        .pend (pending),
        .any  (vec_valid),
        .idx  (vec_idx)
    );

    irq_req_fsm u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_on (master_q[0]),
        .pend_any  (vec_valid),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_next = '0;
        unique case (reg_ofs_e'(reg_addr))
            OFS_STATUS:  rd_next = DATA_W'(status_q);
            OFS_PENDING: rd_next = DATA_W'(pending);
            OFS_ENABLE:  rd_next = DATA_W'(enable_q);
            OFS_VECTOR:  rd_next = vec_valid ? DATA_W'(vec_idx) : '1;
            OFS_MASTER:  rd_next = DATA_W'(master_q);
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_ctrl_pkg::*;
#(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DATA_W    = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
    parameter int                 IDX_W     = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               reg_wr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [1:0]         master_q,
    input logic               vec_valid,
    input logic [IDX_W-1:0]   vec_idx
);

    logic               past_ok;
    logic [NUM_SRC-1:0] chk_ack;
    logic [NUM_SRC-1:0] chk_pend;
    logic [NUM_SRC-1:0] below_idx;
    logic [NUM_SRC-1:0] wd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        wd        = reg_wdata[NUM_SRC-1:0];
        chk_ack   = (reg_wr && reg_addr == OFS_ACK) ? wd : '0;
        chk_pend  = status_q & enable_q;
        below_idx = ({{(NUM_SRC-1){1'b0}}, 1'b1} << vec_idx) - 1'b1;
    end

    assert_set_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && reg_addr == OFS_SET_EN)
        |-> enable_q == ($past(enable_q) | $past(wd)));

    assert_clear_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && reg_addr == OFS_CLR_EN)
        |-> enable_q == ($past(enable_q) & ~$past(wd)));

    assert_direct_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && reg_addr == OFS_ENABLE)
        |-> enable_q == $past(wd));

    assert_status_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(status_q) & ~$past(chk_ack)) & ~status_q) == '0);

    assert_level_relatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(src_i) & ~EDGE_MASK) & ~status_q) == '0);

    assert_vector_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (chk_pend[vec_idx] && (chk_pend & below_idx) == '0));

    assert_vector_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> chk_pend == '0);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && irq_o |-> $past(master_q[0] && (chk_pend != '0)));

endmodule

bind irq_ctrl_top irq_ctrl_checker #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .EDGE_MASK (EDGE_MASK),
    .IDX_W     (IDX_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .master_q  (master_q),
    .vec_valid (vec_valid),
    .vec_idx   (vec_idx)
);

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;

    localparam int          NS   = 32;
    localparam int          DW   = 32;
    localparam logic [31:0] EMSK = 32'h0000_FF0F;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_EN  = 3'd2, A_ACK = 3'd3,
                           A_SET  = 3'd4, A_CLR  = 3'd5, A_VEC = 3'd6, A_MST = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [2:0]    addr = '0;
    logic          wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic          rd_req = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    irq_ctrl_top #(
        .NUM_SRC   (NS),
        .DATA_W    (DW),
        .EDGE_MASK (EMSK)
    ) i_irq_ctrl_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .reg_addr  (addr),
        .reg_wr    (wr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        exp_item_t it;
        @(negedge clk);
        addr   = a;
        rd_req = 1'b1;
        it.tag = tag;
        it.exp = exp;
        exp_q.push_back(it);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic drive_src(logic [NS-1:0] v);
        @(negedge clk);
        src = v;
    endtask

    task automatic check_irq(logic exp, string tag);
        repeat (2) @(negedge clk);
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    // monitor: pops expected read items as the design returns data
    initial begin
        exp_item_t it;
        forever begin
            @(posedge clk);
            if (rd_req) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("monitor queue", 32'h1, 32'h0);
                end else begin
                    it = exp_q.pop_front();
                    check(it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: reset values and offset map
        rd(A_STAT, 32'h0, "R1 status after reset");
        rd(A_PEND, 32'h0, "R1 pending after reset");
        rd(A_EN,   32'h0, "R1 enable after reset");
        rd(A_ACK,  32'h0, "R10 ack reads zero");
        rd(A_SET,  32'h0, "R10 set-enable reads zero");
        rd(A_CLR,  32'h0, "R10 clear-enable reads zero");
        rd(A_VEC,  NONE,  "R1 vector empty after reset");
        rd(A_MST,  32'h0, "R1 master after reset");
        check_irq(1'b0, "R1 irq low after reset");

        // R11: master width
        wreg(A_MST, 32'hFFFF_FFFF);
        rd(A_MST, 32'h3, "R11 master keeps two bits");
        wreg(A_MST, 32'h0);
        rd(A_MST, 32'h0, "R11 master cleared");
        wreg(A_MST, 32'h3);

        // R4: atomic set / clear
        wreg(A_SET, 32'h13);
        rd(A_EN, 32'h13, "R4 set-enable first");
        wreg(A_SET, 32'h100);
        rd(A_EN, 32'h113, "R4 set-enable keeps others");
        wreg(A_CLR, 32'h3);
        rd(A_EN, 32'h110, "R4 clear-enable only ones");
        rd(A_SET, 32'h0, "R10 set-enable still reads zero");

        // R2 / R7: edge pulse on disabled source 0
        drive_src(32'h1);
        drive_src(32'h0);
        rd(A_STAT, 32'h1, "R2 edge latched after input fell");
        rd(A_PEND, 32'h0, "R7 disabled source not pending");
        rd(A_VEC,  NONE,  "R8 vector empty while masked");
        check_irq(1'b0, "R9 no irq while masked");

        wreg(A_SET, 32'h1);
        rd(A_PEND, 32'h1, "R7 pending after enable");
        rd(A_VEC, 32'h0, "R8 vector source 0");
        check_irq(1'b1, "R9 irq raised");

        // R3: level source 4
        drive_src(32'h10);
        rd(A_STAT, 32'h11, "R3 level source latched");
        rd(A_VEC, 32'h0, "R8 lowest index wins");
        wreg(A_ACK, 32'h1);
        rd(A_STAT, 32'h10, "R6 ack clears written bit");
        rd(A_VEC, 32'h4, "R8 vector moves to source 4");
        wreg(A_ACK, 32'h10);
        rd(A_STAT, 32'h10, "R3 level relatched while high");
        drive_src(32'h0);
        wreg(A_ACK, 32'h10);
        rd(A_STAT, 32'h0, "R3 level cleared once low");
        rd(A_VEC, NONE, "R8 vector empty again");
        check_irq(1'b0, "R9 irq drops with no pending");

        // R9: master gating
        drive_src(32'h10);
        wreg(A_MST, 32'h2);
        check_irq(1'b0, "R9 master bit1 alone no irq");
        wreg(A_MST, 32'h1);
        check_irq(1'b1, "R9 master bit0 raises irq");
        drive_src(32'h0);
        wreg(A_ACK, 32'h10);
        wreg(A_MST, 32'h3);
        check_irq(1'b0, "R9 irq low after ack");

        // R2: edge source held high is not re-latched
        drive_src(32'h2);
        rd(A_STAT, 32'h2, "R2 edge source 1 latched");
        wreg(A_ACK, 32'h2);
        rd(A_STAT, 32'h0, "R2 held edge not relatched");
        drive_src(32'h0);

        // R5 / R6 / R8: several sources
        drive_src(32'h300);
        drive_src(32'h0);
        wreg(A_EN, 32'hFFFF_FFFF);
        rd(A_PEND, 32'h300, "R5 whole-word enable");
        rd(A_VEC, 32'h8, "R8 lowest of 8 and 9");
        wreg(A_ACK, 32'h100);
        rd(A_VEC, 32'h9, "R8 next source 9");
        wreg(A_EN, 32'h0);
        rd(A_PEND, 32'h0, "R5 zero write disables all");
        rd(A_VEC, NONE, "R8 vector empty when disabled");
        check_irq(1'b0, "R5 irq low after disable");
        rd(A_STAT, 32'h200, "R7 status kept while disabled");
        wreg(A_ACK, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R6 ack all-ones clears all");

        // R10: read-only registers ignore writes
        wreg(A_STAT, 32'hFFFF);
        rd(A_STAT, 32'h0, "R10 status write ignored");
        wreg(A_PEND, 32'hFFFF);
        rd(A_PEND, 32'h0, "R10 pending write ignored");
        wreg(A_VEC, 32'h5);
        rd(A_VEC, NONE, "R10 vector write ignored");
        rd(A_EN, 32'h0, "R10 enable untouched by ignored writes");

        repeat (4) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule